// File: doc/BRIEF.md
# Paced Two-Wire Serial Boot Transmitter

This block drives the sending end of a one-way link made of a strobe wire and a data wire. A single start request latches a type code, a first address and an exclusive limit address. The block then sends a five-byte header and, after it, one payload byte for every address from the first address up to but not including the limit. The payload bytes come from a simple request/valid interface. Each byte goes out least significant bit first. Each bit is one strobe pulse, and the data line is already settled when the strobe rises.

The receiver is slow and samples in software, so every interval is paced. Header bits use a long period and get an extra gap after each byte. Payload bits use a short period and get a shorter gap after each byte. Before any payload byte whose destination address has a low byte of zero, the block waits an additional long pause so the receiver can handle the page change. All intervals are parameters in microseconds and are converted to whole clock cycles, rounding up, from a clock-frequency parameter. In the table below, HBIT, HGAP, PBIT, PGAP, PAGE and STB are these converted cycle counts.

Top module: `bootlink_tx`

## Requirements
- R1: The header is sent in this order: type code, limit address high byte, limit address low byte, first address high byte, first address low byte.
- R2: The bits of every byte are sent least significant bit first, one bit per strobe pulse. The receiver takes the data value while the strobe is high.
- R3: The data line holds its new value for at least one cycle before the strobe rises. It does not change while the strobe is high or in the cycle the strobe falls.
- R4: Every strobe pulse stays high for exactly STB cycles, the rounded-up cycle count of the strobe width (15 µs by default).
- R5: Within a header byte, strobe rises are HBIT cycles apart (2 ms by default). From the last bit of one header byte to the first bit of the next, the spacing is HBIT+HGAP (HGAP is 1 ms by default).
- R6: Within a payload byte, strobe rises are PBIT cycles apart (80 µs by default). After the last bit of any byte that is followed by a payload byte, the byte request rises at that last strobe rise plus the byte's bit period plus its trailing gap, minus 2 cycles. The trailing gap is HGAP for the last header byte and PGAP (125 µs) for a payload byte.
- R7: The byte request stays high until the byte valid input is seen high. A byte is accepted in the cycle where the request and valid are both high. Its first strobe rises 3 cycles after that cycle. If the byte's destination address has a low byte of 0x00, the first strobe rises 3+PAGE cycles after acceptance instead (PAGE is 2 ms by default).
- R8: Exactly (limit − first) modulo 2^16 payload bytes are sent, in address order. This count may be zero, and the address range may wrap past 0xFFFF.
- R9: A start request seen while idle raises busy one cycle later, and the first strobe rises three cycles after the request. A start request seen while busy is ignored, and the transfer goes on with the values latched first.
- R10: Done is a one-cycle pulse. It comes at the last strobe rise of the transfer plus the last byte's bit period plus its trailing gap, minus 2 cycles. Busy is low in that same cycle.
- R11: While reset is held, the strobe, data, byte request, busy and done outputs are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| kind_i | input | 8 | Type code sent as the first header byte |
| first_addr_i | input | 16 | Address of the first payload byte |
| limit_addr_i | input | 16 | First address not sent (exclusive end) |
| byte_req_o | output | 1 | Next payload byte wanted |
| byte_valid_i | input | 1 | Payload byte present on byte_data_i |
| byte_data_i | input | 8 | Payload byte |
| ser_clk_o | output | 1 | Link strobe |
| ser_dat_o | output | 1 | Link data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Every timed result has a fixed latency, counted from the most recent event the bench has seen:
- After a start request, busy follows one cycle later and the first strobe rise three cycles later.
- After an accepted byte, its first strobe rise follows three cycles later, plus PAGE when its address low byte is zero.
- After a strobe rise, the next rise follows the period for its phase, plus the header gap at header byte boundaries.
- After the last rise of a byte, the next byte request or done follows at the bit period plus the trailing gap minus two cycles.
- After a strobe rise, the strobe falls exactly STB cycles later.

The bench keeps a cycle counter. It samples all outputs on the falling clock edge. It compares each strobe rise, byte request, strobe fall and done pulse against the single cycle predicted from the event before it, so an early or late edge fails on its own. It also decodes the strobed bits into bytes and compares them with the header and payload it built itself.

// File: rtl/bootlink_pkg.sv
// Shared types and helpers for the paced boot-link transmitter.
// Assumes: all timing inputs are whole microseconds.
package bootlink_pkg;

    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int HDR_BYTES  = 1 + 2 * ADDR_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BITS,
        ST_GAP,
        ST_FETCH,
        ST_PAUSE
    } tx_state_t;

    // Converts a duration in microseconds to clock cycles, rounding up.
    function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                     input longint unsigned dur_us);
        return (clk_hz * dur_us + 64'd999_999) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/bootlink_timer.sv
// Interval counter for the transmitter.
// Counts from 0 up to limit-1, flags the final cycle and wraps to 0 on its own.
// Assumes: limit >= 1. A synchronous clear forces the count to zero.
module bootlink_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    assign last = (count == limit - CNT_W'(1));

    // Advance the count, or wrap at the end of the interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (last) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bootlink_shifter.sv
// Byte shifter: presents the LSB and shifts right one place per bit slot.
// Assumes: load and shift are never high in the same cycle.
module bootlink_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         lsb,
    output logic         last_bit
);

    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     sr_q;
    logic [IDX_W-1:0] idx_q;

    assign lsb      = sr_q[0];
    assign last_bit = (idx_q == IDX_W'(W - 1));

    // Load a new byte, or move the next bit into the LSB position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= load_val;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= sr_q >> 1;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

endmodule

// File: rtl/bootlink_hdr.sv
// Header byte selector.
// Byte 0 is the type code, then the limit address MSB first,
// then the first address MSB first.
// Assumes: indexes at or above the header length return zero.
module bootlink_hdr
    import bootlink_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [BYTE_W-1:0] kind_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] hb [HDR_BYTES];

    assign hb[0] = kind_i;

    // Split each address into bytes, most significant byte first.
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
        assign hb[1 + i]              = limit_i[ADDR_W-1-BYTE_W*i -: BYTE_W];
        assign hb[1 + ADDR_BYTES + i] = first_i[ADDR_W-1-BYTE_W*i -: BYTE_W];
    end

    // Pick the indexed header byte.
    always_comb begin
        byte_o = '0;
        if (int'(idx_i) < HDR_BYTES) byte_o = hb[idx_i];
    end

endmodule

// File: rtl/bootlink_tx.sv
// Paced two-wire serial boot transmitter (top).
// Sends the header, then the payload from first to limit (exclusive).
// Every byte goes out LSB first, one strobe pulse per bit.
// Slot timing: data is registered at slot cycle 0, and the strobe is high
// during slot cycles 1..STB (seen one cycle later at the output registers).
// Assumes: STB_CYC + 2 <= PBIT_CYC and STB_CYC + 2 <= HBIT_CYC,
// and every interval is at least one cycle.
module bootlink_tx
    import bootlink_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned HDR_BIT_US = 2000,
    parameter int unsigned HDR_GAP_US = 1000,
    parameter int unsigned PAY_BIT_US = 80,
    parameter int unsigned PAY_GAP_US = 125,
    parameter int unsigned PAGE_US    = 2000,
    parameter int unsigned STROBE_US  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        kind_i,
    input  logic [15:0]       first_addr_i,
    input  logic [15:0]       limit_addr_i,
    output logic              byte_req_o,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_data_i,
    output logic              ser_clk_o,
    output logic              ser_dat_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned HBIT_CYC = int'(us_to_cycles(CLK_HZ, HDR_BIT_US));
    localparam int unsigned HGAP_CYC = int'(us_to_cycles(CLK_HZ, HDR_GAP_US));
    localparam int unsigned PBIT_CYC = int'(us_to_cycles(CLK_HZ, PAY_BIT_US));
    localparam int unsigned PGAP_CYC = int'(us_to_cycles(CLK_HZ, PAY_GAP_US));
    localparam int unsigned PAGE_CYC = int'(us_to_cycles(CLK_HZ, PAGE_US));
    localparam int unsigned STB_CYC  = int'(us_to_cycles(CLK_HZ, STROBE_US));
    localparam int unsigned MAX_A    = (HBIT_CYC > HGAP_CYC) ? HBIT_CYC : HGAP_CYC;
    localparam int unsigned MAX_B    = (PAGE_CYC > PGAP_CYC) ? PAGE_CYC : PGAP_CYC;
    localparam int unsigned MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_LIM  = (MAX_C > PBIT_CYC) ? MAX_C : PBIT_CYC;
    localparam int CNT_W = $clog2(MAX_LIM + 1);
    localparam int HIX_W = $clog2(HDR_BYTES);

    tx_state_t         state_q;
    logic              is_hdr_q;
    logic [HIX_W-1:0]  hdr_idx_q;
    logic [BYTE_W-1:0] kind_q;
    logic [ADDR_W-1:0] first_q, limit_q, cur_q;
    logic              done_q, sclk_q, sdat_q;

    logic [CNT_W-1:0]  t_limit, t_count;
    logic              t_last, t_clear;
    logic              sh_load, sh_shift, sh_lsb, sh_last;
    logic [BYTE_W-1:0] sh_val, hdr_byte;
    logic              hdr_more;

    assign busy_o     = (state_q != ST_IDLE);
    assign byte_req_o = (state_q == ST_FETCH);
    assign done_o     = done_q;
    assign ser_clk_o  = sclk_q;
    assign ser_dat_o  = sdat_q;
    assign hdr_more   = is_hdr_q && (hdr_idx_q != HIX_W'(HDR_BYTES - 1));
    assign t_clear    = (state_q == ST_IDLE) || (state_q == ST_FETCH);

    // Pick the length of the interval the current state is timing.
    always_comb begin
        unique case (state_q)
            ST_BITS:  t_limit = is_hdr_q ? CNT_W'(HBIT_CYC) : CNT_W'(PBIT_CYC);
            ST_GAP:   t_limit = is_hdr_q ? CNT_W'(HGAP_CYC) : CNT_W'(PGAP_CYC);
            ST_PAUSE: t_limit = CNT_W'(PAGE_CYC);
            default:  t_limit = CNT_W'(1);
        endcase
    end

    // Decide when and what the shifter loads, and when it shifts.
    always_comb begin
        sh_load  = 1'b0;
        sh_val   = byte_data_i;
        sh_shift = (state_q == ST_BITS) && t_last && !sh_last;
        unique case (state_q)
            ST_IDLE: begin
                sh_load = start_i;
                sh_val  = kind_i;
            end
            ST_GAP: begin
                sh_load = t_last && hdr_more;
                sh_val  = hdr_byte;
            end
            ST_FETCH: sh_load = byte_valid_i;
            default: ;
        endcase
    end

    bootlink_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .clear(t_clear), .limit(t_limit),
        .count(t_count), .last(t_last)
    );

    bootlink_shifter #(.W(BYTE_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
        .shift(sh_shift), .lsb(sh_lsb), .last_bit(sh_last)
    );

    bootlink_hdr #(.IDX_W(HIX_W)) hdr_i (
        .kind_i(kind_q), .first_i(first_q), .limit_i(limit_q),
        .idx_i(hdr_idx_q + HIX_W'(1)), .byte_o(hdr_byte)
    );

    // Sequence the transfer: header bytes, gaps, fetches, page pauses, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            is_hdr_q  <= 1'b0;
            hdr_idx_q <= '0;
            kind_q    <= '0;
            first_q   <= '0;
            limit_q   <= '0;
            cur_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    kind_q    <= kind_i;
                    first_q   <= first_addr_i;
                    limit_q   <= limit_addr_i;
                    cur_q     <= first_addr_i;
                    is_hdr_q  <= 1'b1;
                    hdr_idx_q <= '0;
                    state_q   <= ST_BITS;
                end
                ST_BITS: if (t_last && sh_last) state_q <= ST_GAP;
                ST_GAP: if (t_last) begin
                    if (hdr_more) begin
                        hdr_idx_q <= hdr_idx_q + HIX_W'(1);
                        state_q   <= ST_BITS;
                    end else begin
                        is_hdr_q <= 1'b0;
                        if (cur_q != limit_q) begin
                            state_q <= ST_FETCH;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_FETCH: if (byte_valid_i) begin
                    cur_q   <= cur_q + ADDR_W'(1);
                    state_q <= (cur_q[BYTE_W-1:0] == '0) ? ST_PAUSE : ST_BITS;
                end
                ST_PAUSE: if (t_last) state_q <= ST_BITS;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the link outputs so the wires never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sdat_q <= 1'b0;
        end else begin
            sclk_q <= (state_q == ST_BITS) && (t_count >= CNT_W'(1))
                      && (t_count <= CNT_W'(STB_CYC));
            sdat_q <= (state_q == ST_BITS) ? sh_lsb : 1'b0;
        end
    end

    // Length of the current strobe pulse, kept for the width check below.
    int unsigned hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_run_q <= 0;
        else if (sclk_q) hi_run_q <= hi_run_q + 1;
        else             hi_run_q <= 0;
    end

    a_r3_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $stable(ser_dat_o));
    a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dat_o));
    a_r3_hold_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk_o) |-> $stable(ser_dat_o));
    a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk_o) |-> (hi_run_q == STB_CYC));
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req_o && !byte_valid_i) |=> byte_req_o);
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(kind_q) && $stable(first_q) && $stable(limit_q)));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/bootlink_tx_tb_top.sv
// Self-checking bench for bootlink_tx.
// Uses random payloads and gaps with a fixed seed, plus directed corner cases.
module bootlink_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_HZ = 100_000;
    // Cycle counts at 100 kHz, rounded up: 2 ms, 1 ms, 80 us, 125 us, 2 ms, 15 us.
    localparam int HBIT = 200;
    localparam int HGAP = 100;
    localparam int PBIT = 8;
    localparam int PGAP = 13;
    localparam int PAGE = 200;
    localparam int STB  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  kind_i = '0;
    logic [15:0] first_addr_i = '0;
    logic [15:0] limit_addr_i = '0;
    logic        byte_req_o;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        ser_clk_o, ser_dat_o, busy_o, done_o;

    bootlink_tx #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .first_addr_i(first_addr_i), .limit_addr_i(limit_addr_i),
        .byte_req_o(byte_req_o), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Monitor state
    bit prev_clk = 0, prev_dat = 0, prev_req = 0;
    int last_rise = 0, bitn = 0, byte_i = 0, pay_total = 0, done_seen = 0;
    int exp_rise = 0, exp_req = -1, exp_done = -1;
    bit exp_rise_on = 0;
    string exp_tag = "R9";
    logic [7:0] acc = '0;
    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One cycle: wait for the falling edge, then check the outputs against the timing model.
    task automatic step();
        int nxt;
        @(negedge clk);
        if (ser_clk_o && !prev_clk) begin
            chk(exp_rise_on && cyc == exp_rise, exp_tag, cyc, exp_rise);
            chk(ser_dat_o == prev_dat, "R3", int'(ser_dat_o), int'(prev_dat));
            last_rise = cyc;
            acc[bitn] = ser_dat_o;
            if (bitn < 7) begin
                bitn++;
                exp_rise = cyc + ((byte_i < 5) ? HBIT : PBIT);
                exp_tag  = (byte_i < 5) ? "R5" : "R6";
            end else begin
                rx_q.push_back(acc);
                bitn = 0;
                byte_i++;
                if (byte_i < 5) begin
                    exp_rise = cyc + HBIT + HGAP;
                    exp_tag  = "R5";
                end else begin
                    exp_rise_on = 0;
                    nxt = cyc + ((byte_i == 5) ? HBIT + HGAP : PBIT + PGAP) - 2;
                    if (byte_i - 5 < pay_total) exp_req = nxt;
                    else exp_done = nxt;
                end
            end
        end
        if (ser_clk_o && prev_clk)
            chk(ser_dat_o == prev_dat, "R3", int'(ser_dat_o), int'(prev_dat));
        if (!ser_clk_o && prev_clk) begin
            chk(cyc - last_rise == STB, "R4", cyc - last_rise, STB);
            chk(ser_dat_o == prev_dat, "R3", int'(ser_dat_o), int'(prev_dat));
        end
        if (byte_req_o && !prev_req) chk(cyc == exp_req, "R6", cyc, exp_req);
        if (done_o) begin
            chk(cyc == exp_done, "R10", cyc, exp_done);
            chk(!busy_o, "R10", int'(busy_o), 0);
            done_seen++;
        end
        prev_clk = ser_clk_o;
        prev_dat = ser_dat_o;
        prev_req = byte_req_o;
    endtask

    task automatic run_transfer(input logic [7:0] kind, input logic [15:0] fa,
                                input logic [15:0] la, input int maxd, input bit inject);
        int n, c, wait_left, guard;
        logic [15:0] addr;
        n = int'(16'(la - fa));
        rx_q.delete();
        exp_q.delete();
        exp_q.push_back(kind);
        exp_q.push_back(la[15:8]);
        exp_q.push_back(la[7:0]);
        exp_q.push_back(fa[15:8]);
        exp_q.push_back(fa[7:0]);
        pay_total = n; byte_i = 0; bitn = 0; done_seen = 0;
        exp_req = -1; exp_done = -1;
        addr = fa;
        kind_i = kind; first_addr_i = fa; limit_addr_i = la; start_i = 1'b1;
        c = cyc;
        exp_rise = c + 3; exp_rise_on = 1; exp_tag = "R9";
        step();
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
        wait_left = -1;
        guard = 0;
        while (done_seen == 0 && guard < 40000) begin
            guard++;
            if (inject && guard == 50) begin
                // R9: a second start while busy must not change the header or payload
                kind_i = ~kind; first_addr_i = fa + 16'h0101; limit_addr_i = la ^ 16'h00F0;
                start_i = 1'b1;
                step();
                start_i = 1'b0;
                continue;
            end
            if (byte_req_o) begin
                if (wait_left < 0) wait_left = int'($urandom_range(maxd, 0));
                if (wait_left == 0) begin
                    byte_data_i = 8'($urandom);
                    byte_valid_i = 1'b1;
                    exp_q.push_back(byte_data_i);
                    exp_rise = cyc + 3 + ((addr[7:0] == 8'h00) ? PAGE : 0);
                    exp_rise_on = 1;
                    exp_tag = "R7";
                    addr = addr + 16'd1;
                    wait_left = -1;
                    step();
                    byte_valid_i = 1'b0;
                    chk(!byte_req_o, "R7", int'(byte_req_o), 0);
                    continue;
                end
                wait_left--;
            end
            step();
        end
        chk(done_seen == 1, "R10", done_seen, 1);
        for (int k = 0; k < 20; k++) step();
        chk(!busy_o, "R10", int'(busy_o), 0);
        chk(rx_q.size() == exp_q.size(), "R8", rx_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < rx_q.size(); k++)
            chk(rx_q[k] == exp_q[k], (k < 5) ? "R1" : "R2", int'(rx_q[k]), int'(exp_q[k]));
    endtask

    initial begin
        int seed_dummy;
        logic [15:0] fa;
        seed_dummy = int'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!ser_clk_o && !ser_dat_o, "R11", int'(ser_clk_o) + int'(ser_dat_o), 0);
        chk(!byte_req_o && !busy_o && !done_o, "R11",
            int'(byte_req_o) + int'(busy_o) + int'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) step();
        // Page crossing inside the payload, random stalls, start ignored while busy
        run_transfer(8'h4B, 16'h12FD, 16'h1303, 3, 1'b1);
        // First payload byte lands on a page start
        run_transfer(8'h4D, 16'h4000, 16'h4003, 0, 1'b0);
        // Zero-length payload: done right after the header
        run_transfer(8'h4C, 16'h2222, 16'h2222, 0, 1'b0);
        // Address range wraps through 0x0000
        run_transfer(8'h4E, 16'hFFFE, 16'h0002, 2, 1'b0);
        // Random ranges and stalls
        for (int t = 0; t < 2; t++) begin
            fa = 16'($urandom);
            run_transfer(8'($urandom), fa, fa + 16'($urandom_range(20, 1)), 4, 1'b0);
        end
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        summary();
    end

endmodule